// File: doc/BRIEF.md
# Display Column Address Pointer with Read-Modify-Write

This block keeps the column address used to reach a display frame memory. A host loads the address four bits at a time. One command strobe replaces the low nibble and another replaces the high nibble. After each display data access the pointer moves to the next column. It wraps to zero after the last column.

A read-modify-write mode supports patching memory contents in place. On entry the block saves the current column. While the mode is active, data reads leave the pointer where it is and data writes still advance it. This lets a host read a location and then overwrite it without reloading the address. On exit the saved column comes back. A software reset leaves the mode without restoring the column.

The command strobes come from an upstream command decoder, which presents at most one command per cycle. The access strobes come from the data port.

Top module: `colptr_top`

## Requirements
- R1: `cmd_lo_nib` loads `nib_val` into address bits [3:0] on the next clock edge, and bits [7:4] keep their value.
- R2: `cmd_hi_nib` loads `nib_val` into address bits [7:4] on the next clock edge, and bits [3:0] keep their value.
- R3: After reset the column address is 0x00 and read-modify-write mode is off, so a read advances the address.
- R4: Outside read-modify-write mode, a cycle with `rd_stb`, `wr_stb` or both high advances the address by exactly one.
- R5: An advance from address MAX_COL (default 0x83) or from any higher value gives 0x00.
- R6: `cmd_rmw_enter` saves the current column and turns the mode on. While the mode is on, a read alone leaves the address unchanged.
- R7: While read-modify-write mode is on, a write still advances the address by one.
- R8: `cmd_rmw_exit` while the mode is on restores the saved column on the next edge and turns the mode off.
- R9: `cmd_rmw_enter` while the mode is already on does not change the saved column.
- R10: `cmd_rmw_exit` while the mode is off leaves the address unchanged.
- R11: `cmd_sreset` turns the mode off and keeps the current address, so later reads advance again.
- R12: In a cycle with any command strobe high, the access strobes are ignored. Among the column updates, a restore wins over a high-nibble load, and a high-nibble load wins over a low-nibble load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_lo_nib | input | 1 | Load the low nibble of the column |
| cmd_hi_nib | input | 1 | Load the high nibble of the column |
| nib_val | input | NIB_W | Nibble value for the load commands |
| cmd_rmw_enter | input | 1 | Enter read-modify-write mode |
| cmd_rmw_exit | input | 1 | Leave read-modify-write mode and restore the column |
| cmd_sreset | input | 1 | Software reset of the mode state |
| rd_stb | input | 1 | Display data read access |
| wr_stb | input | 1 | Display data write access |
| col_addr | output | 2*NIB_W | Current column address |

## Verification
The hardest case to reach is a second entry command given while the mode is already on, after writes have moved the pointer. If the saved column were overwritten there, the effect would only appear at the later exit. The bench loads 0x20, enters the mode, writes three times, reads twice, enters again at 0x23 and then exits. It expects 0x20 and not 0x23. The wrap is reached by loading 0x83 and 0xF5 directly through the two nibble commands. The bench also checks that a software reset given inside the mode lets reads advance again.

// File: rtl/colptr_pkg.sv
package colptr_pkg;
   typedef enum logic [1:0] {
      UPD_HOLD    = 2'd0,
      UPD_RESTORE = 2'd1,
      UPD_LOAD    = 2'd2,
      UPD_STEP    = 2'd3
   } colptr_upd_e;
endpackage

// File: rtl/colptr_step.sv
module colptr_step #(
   parameter int AW      = 8,
   parameter int MAX_COL = 131
) (
   input  logic [AW-1:0] cur,
   output logic [AW-1:0] nxt
);
   localparam logic [AW-1:0] LAST = AW'(MAX_COL);
   localparam bit FULL_RANGE = (MAX_COL == (1 << AW) - 1);

   generate
      if (FULL_RANGE) begin : g_natural
         always_comb nxt = cur + AW'(1);
      end else begin : g_compare
         always_comb nxt = (cur >= LAST) ? '0 : cur + AW'(1);
      end
   endgenerate
endmodule

// File: rtl/colptr_rmw.sv
module colptr_rmw #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enter,
   input  logic          leave,
   input  logic          sreset,
   input  logic [AW-1:0] cur_col,
   output logic          active,
   output logic          restore,
   output logic [AW-1:0] saved
);
   logic capture;

   always_comb begin
      restore = leave && active;
      capture = enter && !active && !leave && !sreset;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         saved  <= '0;
      end else begin
         if (leave || sreset) active <= 1'b0;
         else if (capture)    active <= 1'b1;
         if (capture) saved <= cur_col;
      end
   end

   p_save_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && enter && !leave && !sreset) |=> ($stable(saved) && active));

   p_sreset_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sreset |=> !active);
endmodule

// File: rtl/colptr_top.sv
module colptr_top
   import colptr_pkg::*;
#(
   parameter int NIB_W   = 4,
   parameter int MAX_COL = 131
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_lo_nib,
   input  logic               cmd_hi_nib,
   input  logic [NIB_W-1:0]   nib_val,
   input  logic               cmd_rmw_enter,
   input  logic               cmd_rmw_exit,
   input  logic               cmd_sreset,
   input  logic               rd_stb,
   input  logic               wr_stb,
   output logic [2*NIB_W-1:0] col_addr
);
   localparam int AW = 2 * NIB_W;

   generate
      if (NIB_W < 1) begin : g_bad_nib
         $error("NIB_W must be at least 1");
      end
      if (MAX_COL < 1 || MAX_COL >= (1 << AW)) begin : g_bad_max
         $error("MAX_COL must fit in the address width");
      end
   endgenerate

   logic          rmw_on, do_restore;
   logic [AW-1:0] saved_col, stepped, loaded, col_q, col_d;
   logic          any_cmd, access;
   colptr_upd_e   upd;

   colptr_step #(.AW(AW), .MAX_COL(MAX_COL)) u_step (
      .cur (col_q),
      .nxt (stepped)
   );

   colptr_rmw #(.AW(AW)) u_rmw (
      .clk     (clk),
      .rst_n   (rst_n),
      .enter   (cmd_rmw_enter),
      .leave   (cmd_rmw_exit),
      .sreset  (cmd_sreset),
      .cur_col (col_q),
      .active  (rmw_on),
      .restore (do_restore),
      .saved   (saved_col)
   );

   always_comb begin
      any_cmd = cmd_lo_nib | cmd_hi_nib | cmd_rmw_enter | cmd_rmw_exit | cmd_sreset;
      access  = wr_stb | (rd_stb & ~rmw_on);
      loaded  = cmd_hi_nib ? {nib_val, col_q[NIB_W-1:0]}
                           : {col_q[AW-1:NIB_W], nib_val};
      if (do_restore)                   upd = UPD_RESTORE;
      else if (cmd_hi_nib | cmd_lo_nib) upd = UPD_LOAD;
      else if (!any_cmd && access)      upd = UPD_STEP;
      else                              upd = UPD_HOLD;
      unique case (upd)
         UPD_RESTORE: col_d = saved_col;
         UPD_LOAD:    col_d = loaded;
         UPD_STEP:    col_d = stepped;
         default:     col_d = col_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) col_q <= '0;
      else        col_q <= col_d;
   end

   assign col_addr = col_q;

   p_lo_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_lo_nib && !cmd_hi_nib && !do_restore) |=>
      (col_addr[AW-1:NIB_W] == $past(col_addr[AW-1:NIB_W]) &&
       col_addr[NIB_W-1:0] == $past(nib_val)));

   p_hi_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hi_nib && !do_restore) |=>
      (col_addr[NIB_W-1:0] == $past(col_addr[NIB_W-1:0]) &&
       col_addr[AW-1:NIB_W] == $past(nib_val)));

   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_cmd && wr_stb && col_addr >= AW'(MAX_COL)) |=> (col_addr == '0));

   p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rmw_on && rd_stb && !wr_stb && !any_cmd) |=> $stable(col_addr));

   p_exit_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rmw_on && cmd_rmw_exit) |=> (col_addr == $past(saved_col) && !rmw_on));

   p_cmd_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_rmw_enter || cmd_sreset) && !cmd_lo_nib && !cmd_hi_nib && !cmd_rmw_exit)
      |=> $stable(col_addr));
endmodule

// File: tb/tb_colptr_top.sv
module tb_colptr_top;
   localparam int CLK_PERIOD = 10;
   localparam int NIB_W = 4;
   localparam int AW = 8;
   localparam int MAX_COL = 131;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_lo_nib = 0, cmd_hi_nib = 0, cmd_rmw_enter = 0, cmd_rmw_exit = 0;
   logic cmd_sreset = 0, rd_stb = 0, wr_stb = 0;
   logic [NIB_W-1:0] nib_val = '0;
   logic [AW-1:0] col_addr;

   int checks = 0, errors = 0;
   logic [AW-1:0] exp_q[$];
   string tag_q[$];
   logic [AW-1:0] m_col = '0, m_saved = '0;
   logic m_rmw = 1'b0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   colptr_top #(.NIB_W(NIB_W), .MAX_COL(MAX_COL)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_lo_nib(cmd_lo_nib), .cmd_hi_nib(cmd_hi_nib),
      .nib_val(nib_val), .cmd_rmw_enter(cmd_rmw_enter), .cmd_rmw_exit(cmd_rmw_exit),
      .cmd_sreset(cmd_sreset), .rd_stb(rd_stb), .wr_stb(wr_stb), .col_addr(col_addr)
   );

   // monitor: compares one queued expectation per falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [AW-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (col_addr !== e) begin
            errors++;
            $display("FAIL %s col_addr actual %02h expected %02h", t, col_addr, e);
         end
      end
   end

   task automatic op(input bit lo, input bit hi, input logic [3:0] nib,
                     input bit en, input bit ex, input bit sr,
                     input bit rd, input bit wr, input string tag);
      logic [AW-1:0] nc;
      @(negedge clk);
      cmd_lo_nib = lo; cmd_hi_nib = hi; nib_val = nib; cmd_rmw_enter = en;
      cmd_rmw_exit = ex; cmd_sreset = sr; rd_stb = rd; wr_stb = wr;
      nc = m_col;
      if (ex && m_rmw)               nc = m_saved;
      else if (hi)                   nc = {nib, m_col[3:0]};
      else if (lo)                   nc = {m_col[7:4], nib};
      else if (en || ex || sr)       nc = m_col;
      else if (wr || (rd && !m_rmw)) nc = (m_col >= AW'(MAX_COL)) ? '0 : m_col + 1'b1;
      if (sr || ex) m_rmw = 1'b0;
      else if (en && !m_rmw) begin m_rmw = 1'b1; m_saved = m_col; end
      m_col = nc;
      @(posedge clk);
      #1;
      cmd_lo_nib = 0; cmd_hi_nib = 0; cmd_rmw_enter = 0; cmd_rmw_exit = 0;
      cmd_sreset = 0; rd_stb = 0; wr_stb = 0;
      exp_q.push_back(m_col);
      tag_q.push_back(tag);
   endtask

   task automatic load(input logic [7:0] v, input string tag);
      op(0, 1, v[7:4], 0, 0, 0, 0, 0, tag);
      op(1, 0, v[3:0], 0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (col_addr !== 8'h00) begin
         errors++;
         $display("FAIL R3 reset col_addr actual %02h expected 00", col_addr);
      end
      @(negedge clk) rst_n = 1'b1;
      op(0, 0, 0, 0, 0, 0, 1, 0, "R3");               // read advances after reset: 01
      op(1, 0, 4'hA, 0, 0, 0, 0, 0, "R1");            // 0A
      op(0, 1, 4'h5, 0, 0, 0, 0, 0, "R2");            // 5A
      op(1, 0, 4'h3, 0, 0, 0, 0, 0, "R1");            // 53
      op(0, 0, 0, 0, 0, 0, 0, 1, "R4");               // write 54
      op(0, 0, 0, 0, 0, 0, 1, 1, "R4");               // both 55
      load(8'h83, "R5");
      op(0, 0, 0, 0, 0, 0, 0, 1, "R5");               // wrap 00
      load(8'hF5, "R5");
      op(0, 0, 0, 0, 0, 0, 1, 0, "R5");               // wrap from above max
      load(8'h20, "R6");
      op(0, 0, 0, 1, 0, 0, 0, 0, "R6");               // enter at 20
      for (int i = 0; i < 3; i++) op(0, 0, 0, 0, 0, 0, 0, 1, "R7");
      for (int i = 0; i < 2; i++) op(0, 0, 0, 0, 0, 0, 1, 0, "R6");
      op(0, 0, 0, 1, 0, 0, 0, 0, "R9");               // enter again at 23
      op(0, 0, 0, 0, 0, 0, 1, 0, "R6");
      op(0, 0, 0, 0, 1, 0, 0, 0, "R8");               // restore 20
      op(0, 0, 0, 0, 0, 0, 1, 0, "R8");               // mode off: reads advance
      op(0, 0, 0, 0, 1, 0, 0, 0, "R10");              // exit while off
      op(0, 0, 0, 1, 0, 0, 0, 0, "R11");
      op(0, 0, 0, 0, 0, 0, 0, 1, "R11");
      op(0, 0, 0, 0, 0, 1, 0, 0, "R11");              // sreset keeps column
      op(0, 0, 0, 0, 0, 0, 1, 0, "R11");              // read advances again
      op(1, 0, 4'h7, 0, 0, 0, 1, 1, "R12");           // load beats access
      op(1, 1, 4'h9, 0, 0, 0, 0, 0, "R12");           // hi beats lo
      op(0, 0, 0, 1, 0, 0, 0, 1, "R12");              // enter blocks write
      op(0, 1, 4'h1, 0, 1, 0, 0, 0, "R12");           // restore beats hi
      repeat (3) @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule